// File: doc/BRIEF.md
# Crystal Clock Failure Detector with Internal-Clock Failover

This block watches an external crystal oscillator clock and uses the always-running internal RC clock as its time base. All of its logic runs on the internal clock. The crystal clock is brought in through a synchroniser and checked for rising edges. Software arms the watchdog with an enable bit. If the crystal then goes quiet for a fixed window, the block takes four actions:

- it moves the system clock to the internal RC oscillator;
- it switches the crystal oscillator off;
- it switches the PLL off, but only when the PLL takes its reference from the crystal;
- it raises a non-maskable interrupt request and a brake for the motor-control timer.

The check looks at the crystal edges themselves and never at the system clock. A PLL that has lost its reference still oscillates at a low rate, so the presence of a system clock proves nothing about the crystal.

The block also arbitrates ordinary source changes requested by software. It drives one gate-enable line per clock source to an external switching cell. It always drops the old gate and waits a dead interval before it raises the new one.

Top module: `xosc_failover`

## Requirements
- R1: After reset the following hold: `src_stat` is 00, `clk_gate` is 001, `xosc_en` and `pll_en` are 0, and `nmi_req` and `tim_brake` are 0.
- R2: Source codes are 00 for the internal RC, 01 for the crystal and 10 for the PLL. A request of 00, 01 or 10 on `src_req` becomes the reported `src_stat` once the switch sequence completes. A request of 11 is ignored and leaves `src_stat` unchanged.
- R3: `clk_gate` bit 0 gates the internal RC, bit 1 the crystal and bit 2 the PLL. At most one bit is ever high. On a source change, all bits are low for GAP_CYC reference cycles before the new bit rises.
- R4: Detection is off after reset. It arms only after `mon_en` has been high for a reference cycle and while `xosc_en` is 1.
- R5: Once armed, a failure is declared when 32 (MISS_WIN) consecutive reference cycles pass with no synchronised rising crystal edge. On a failure, `nmi_req` and `tim_brake` rise together.
- R6: On a failure, `xosc_en` is cleared.
- R7: On a failure, `pll_en` is cleared when `pll_ref_xosc` is 1. When `pll_ref_xosc` is 0, `pll_en` keeps its value.
- R8: `nmi_req` and `tim_brake` stay high until a one-cycle pulse on `alarm_clr`.
- R9: After a failure the source is forced to the internal RC, and `src_req` is overridden. This lasts until `xosc_on_set` is pulsed; after that, `src_req` is honoured again.
- R10: While `mon_en` is low, a stopped crystal clock causes no source change, no interrupt, no brake and no change of `xosc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal RC clock, the time base for all logic |
| xosc_clk | input | 1 | Crystal oscillator clock being watched |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Failure-detection enable bit |
| pll_ref_xosc | input | 1 | 1 when the PLL reference is the crystal |
| src_req | input | 2 | Requested system clock source |
| xosc_on_set | input | 1 | Pulse: switch the crystal on and leave failover |
| pll_on_set | input | 1 | Pulse: switch the PLL on |
| alarm_clr | input | 1 | Pulse: clear the interrupt and brake flags |
| src_stat | output | 2 | Active system clock source |
| clk_gate | output | 3 | Per-source gate enables to the switching cell |
| xosc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| nmi_req | output | 1 | Non-maskable interrupt request |
| tim_brake | output | 1 | Brake request to the motor-control timer |

## Verification
The assertions assume three things about the inputs:

- `xosc_on_set`, `pll_on_set` and `alarm_clr` are single-cycle pulses aligned to `ref_clk`;
- `mon_en` and `pll_ref_xosc` are steady around the cycles that matter;
- the crystal clock, while running, produces edges far more often than one per 32 reference cycles.

The stimulus respects these assumptions. It drives all control inputs on falling reference edges and keeps every pulse one cycle wide. The crystal runs at a 6 ns period whose edges fall on half-nanosecond offsets, so a crystal edge never coincides with a reference edge. The crystal is stopped and restarted only through a run flag, which freezes it at its current level.

// File: rtl/xosc_failover.sv
module xosc_failover #(
  parameter int MISS_WIN = 32,
  parameter int GAP_CYC  = 2
) (
  input  logic       ref_clk,
  input  logic       xosc_clk,
  input  logic       rst_n,
  input  logic       mon_en,
  input  logic       pll_ref_xosc,
  input  logic [1:0] src_req,
  input  logic       xosc_on_set,
  input  logic       pll_on_set,
  input  logic       alarm_clr,
  output logic [1:0] src_stat,
  output logic [2:0] clk_gate,
  output logic       xosc_en,
  output logic       pll_en,
  output logic       nmi_req,
  output logic       tim_brake
);
  localparam int CW = (MISS_WIN > 2) ? $clog2(MISS_WIN) : 1;
  localparam int GW = $clog2(GAP_CYC) + 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MISS_WIN - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  logic [2:0]    xs;
  logic          rise;
  logic          mon_q;
  logic          armed;
  logic [CW-1:0] quiet;
  logic          miss;
  logic          fail_q;
  logic          alarm_q;
  logic          xosc_q;
  logic          pll_q;
  logic          gap_q;
  logic [GW-1:0] gcnt;
  logic [1:0]    cur;
  logic [1:0]    tgt;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) xs <= '0;
    else        xs <= {xs[1:0], xosc_clk};

  assign rise  = xs[1] & ~xs[2];
  assign armed = mon_q & xosc_q;
  assign miss  = armed & ~rise & (quiet == CNT_LAST);

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                quiet <= '0;
    else if (!armed || rise)   quiet <= '0;
    else if (quiet != CNT_LAST) quiet <= quiet + 1'b1;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      mon_q   <= 1'b0;
      xosc_q  <= 1'b0;
      pll_q   <= 1'b0;
      fail_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      mon_q <= mon_en;
      if (miss)             xosc_q <= 1'b0;
      else if (xosc_on_set) xosc_q <= 1'b1;
      if (miss && pll_ref_xosc) pll_q <= 1'b0;
      else if (pll_on_set)      pll_q <= 1'b1;
      if (miss)             fail_q <= 1'b1;
      else if (xosc_on_set) fail_q <= 1'b0;
      if (miss)             alarm_q <= 1'b1;
      else if (alarm_clr)   alarm_q <= 1'b0;
    end

  always_comb begin
    if (fail_q)               tgt = 2'b00;
    else if (src_req == 2'b11) tgt = cur;
    else                      tgt = src_req;
  end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      gap_q <= 1'b0;
      gcnt  <= '0;
      cur   <= 2'b00;
    end else if (!gap_q) begin
      if (tgt != cur) begin
        gap_q <= 1'b1;
        gcnt  <= '0;
      end
    end else if (gcnt == GAP_LAST) begin
      gap_q <= 1'b0;
      cur   <= tgt;
    end else begin
      gcnt <= gcnt + 1'b1;
    end

  assign src_stat  = cur;
  assign clk_gate  = gap_q ? 3'b000 : (3'b001 << cur);
  assign xosc_en   = xosc_q;
  assign pll_en    = pll_q;
  assign nmi_req   = alarm_q;
  assign tim_brake = alarm_q;
endmodule

// File: rtl/xosc_failover_check.sv
module xosc_failover_check (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       mon_en,
  input logic       pll_ref_xosc,
  input logic       alarm_clr,
  input logic [1:0] src_stat,
  input logic [2:0] clk_gate,
  input logic       xosc_en,
  input logic       pll_en,
  input logic       nmi_req
);
  a_r3_gate_onehot: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot0(clk_gate));

  a_r3_break_first: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((|clk_gate) && (|$past(clk_gate))) |-> (clk_gate == $past(clk_gate)));

  a_r2_gate_matches_stat: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (|clk_gate) |-> (clk_gate == (3'b001 << src_stat)));

  a_r4_needs_enable: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(mon_en, 2));

  a_r6_xosc_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(nmi_req) |-> !xosc_en);

  a_r7_pll_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($rose(nmi_req) && $past(pll_ref_xosc)) |-> !pll_en);

  a_r8_alarm_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (nmi_req && !alarm_clr) |=> nmi_req);
endmodule

bind xosc_failover xosc_failover_check u_check (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .mon_en       (mon_en),
  .pll_ref_xosc (pll_ref_xosc),
  .alarm_clr    (alarm_clr),
  .src_stat     (src_stat),
  .clk_gate     (clk_gate),
  .xosc_en      (xosc_en),
  .pll_en       (pll_en),
  .nmi_req      (nmi_req)
);

// File: tb/xosc_failover_tb_top.sv
`timescale 1ns/100ps
module xosc_failover_tb_top;
  localparam int WIN = 32;
  localparam int GAP = 2;

  logic       ref_clk = 1'b0;
  logic       xosc_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mon_en = 1'b0;
  logic       pll_ref_xosc = 1'b0;
  logic [1:0] src_req = 2'b00;
  logic       xosc_on_set = 1'b0;
  logic       pll_on_set = 1'b0;
  logic       alarm_clr = 1'b0;
  logic [1:0] src_stat;
  logic [2:0] clk_gate;
  logic       xosc_en, pll_en, nmi_req, tim_brake;

  bit xrun = 1'b0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2 ref_clk = ~ref_clk;
  initial begin
    #0.5;
    forever begin
      #3;
      if (xrun) xosc_clk = ~xosc_clk;
    end
  end

  xosc_failover #(.MISS_WIN(WIN), .GAP_CYC(GAP)) dut_i (
    .ref_clk(ref_clk), .xosc_clk(xosc_clk), .rst_n(rst_n), .mon_en(mon_en),
    .pll_ref_xosc(pll_ref_xosc), .src_req(src_req), .xosc_on_set(xosc_on_set),
    .pll_on_set(pll_on_set), .alarm_clr(alarm_clr), .src_stat(src_stat),
    .clk_gate(clk_gate), .xosc_en(xosc_en), .pll_en(pll_en),
    .nmi_req(nmi_req), .tim_brake(tim_brake));

  // behavioural reference model
  bit m_h[$];
  int m_quiet, m_g;
  bit m_mon, m_osc, m_pll, m_fail, m_alarm, m_gap;
  int m_cur;

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      m_h = {0, 0, 0};
      m_quiet = 0; m_g = 0; m_cur = 0;
      m_mon = 0; m_osc = 0; m_pll = 0; m_fail = 0; m_alarm = 0; m_gap = 0;
    end else begin
      bit seen, live, lost;
      int want;
      seen = m_h[1] && !m_h[2];
      live = m_mon && m_osc;
      lost = live && !seen && (m_quiet == WIN - 1);
      want = m_fail ? 0 : ((src_req == 2'b11) ? m_cur : int'(src_req));
      m_h.push_front(xosc_clk);
      void'(m_h.pop_back());
      if (!live || seen) m_quiet = 0;
      else if (m_quiet < WIN - 1) m_quiet++;
      m_mon = mon_en;
      if (lost) m_osc = 0; else if (xosc_on_set) m_osc = 1;
      if (lost && pll_ref_xosc) m_pll = 0; else if (pll_on_set) m_pll = 1;
      if (lost) m_fail = 1; else if (xosc_on_set) m_fail = 0;
      if (lost) m_alarm = 1; else if (alarm_clr) m_alarm = 0;
      if (!m_gap) begin
        if (want != m_cur) begin m_gap = 1; m_g = 0; end
      end else if (m_g == GAP - 1) begin
        m_gap = 0; m_cur = want;
      end else m_g++;
    end
  end

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge ref_clk) if (cmp_on) begin
    chk("R2 src_stat vs model", {2'b0, src_stat}, 4'(m_cur));
    chk("R3 clk_gate vs model", {1'b0, clk_gate}, m_gap ? 4'd0 : 4'(1 << m_cur));
    chk("R6 xosc_en vs model", {3'b0, xosc_en}, {3'b0, m_osc});
    chk("R7 pll_en vs model", {3'b0, pll_en}, {3'b0, m_pll});
    chk("R8 nmi_req vs model", {3'b0, nmi_req}, {3'b0, m_alarm});
    chk("R5 tim_brake vs model", {3'b0, tim_brake}, {3'b0, m_alarm});
  end

  task automatic cyc(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulse_xosc(); xosc_on_set = 1; cyc(1); xosc_on_set = 0; endtask
  task automatic pulse_pll();  pll_on_set = 1;  cyc(1); pll_on_set = 0;  endtask
  task automatic pulse_clr();  alarm_clr = 1;   cyc(1); alarm_clr = 0;   endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    cyc(5);
    rst_n = 1;
    cmp_on = 1;
    cyc(1);
    // R1 reset state
    chk("R1 src_stat", {2'b0, src_stat}, 4'd0);
    chk("R1 clk_gate", {1'b0, clk_gate}, 4'd1);
    chk("R1 enables", {2'b0, xosc_en, pll_en}, 4'd0);
    chk("R1 alarm", {2'b0, nmi_req, tim_brake}, 4'd0);

    // R4: crystal on but stopped, detection never enabled since reset
    pulse_xosc();
    cyc(60);
    chk("R4 no alarm before enable", {3'b0, nmi_req}, 4'd0);
    chk("R4 xosc kept", {3'b0, xosc_en}, 4'd1);

    // R2 source selection, R3 dead interval
    xrun = 1; cyc(10);
    src_req = 2'b01; cyc(1);
    chk("R3 gates low in gap", {1'b0, clk_gate}, 4'd0);
    cyc(6);
    chk("R2 crystal selected", {2'b0, src_stat}, 4'd1);
    src_req = 2'b11; cyc(8);
    chk("R2 code 11 ignored", {2'b0, src_stat}, 4'd1);
    pulse_pll();
    src_req = 2'b10; cyc(8);
    chk("R2 pll selected", {2'b0, src_stat}, 4'd2);

    // R10: enable then disable, stop the crystal
    mon_en = 1; cyc(20);
    mon_en = 0; cyc(2);
    xrun = 0; cyc(80);
    chk("R10 no alarm when disabled", {3'b0, nmi_req}, 4'd0);
    chk("R10 source unchanged", {2'b0, src_stat}, 4'd2);
    chk("R10 xosc kept", {3'b0, xosc_en}, 4'd1);

    // R5/R6/R7 failure with PLL fed by crystal
    xrun = 1; pll_ref_xosc = 1; mon_en = 1; cyc(50);
    chk("R5 running crystal no alarm", {3'b0, nmi_req}, 4'd0);
    xrun = 0; cyc(28);
    chk("R5 no alarm before window", {3'b0, nmi_req}, 4'd0);
    cyc(17);
    chk("R5 alarm raised", {2'b0, nmi_req, tim_brake}, 4'd3);
    chk("R6 crystal off", {3'b0, xosc_en}, 4'd0);
    chk("R7 pll off", {3'b0, pll_en}, 4'd0);
    cyc(5);
    chk("R9 forced internal", {2'b0, src_stat}, 4'd0);

    // R8 sticky then clear
    cyc(20);
    chk("R8 alarm held", {3'b0, nmi_req}, 4'd1);
    pulse_clr(); cyc(1);
    chk("R8 alarm cleared", {2'b0, nmi_req, tim_brake}, 4'd0);

    // R9 recovery
    xrun = 1; cyc(10);
    chk("R9 still internal", {2'b0, src_stat}, 4'd0);
    pulse_xosc(); pulse_pll(); cyc(8);
    chk("R9 request honoured", {2'b0, src_stat}, 4'd2);

    // R7 PLL not fed by crystal keeps its enable
    pll_ref_xosc = 0; src_req = 2'b01; cyc(8);
    xrun = 0; cyc(50);
    chk("R7 pll kept", {3'b0, pll_en}, 4'd1);
    chk("R6 crystal off again", {3'b0, xosc_en}, 4'd0);
    chk("R9 forced internal again", {2'b0, src_stat}, 4'd0);
    cyc(5);
    finish_run();
  end
endmodule